// File: doc/BRIEF.md
# Dual-Mode Burst Address Counter

This block supplies the word address for a four-beat burst into a memory array. A load strobe captures a full external word address. Each later advance steps the two lowest address bits through the burst order, and the upper bits stay frozen at the value captured by the load. There are two load strobes, and either one starts a new burst, even in the middle of a burst already running.

The burst order comes from a static mode input. With the mode input high, the order is interleaved: the low bits are the captured low bits XORed with a beat index. With the mode input low, the order is linear: the low bits count up modulo four from the captured value. When the advance input is inactive, the counter holds its value, so a wait state repeats the current address.

The address output is taken directly from registers through a two-bit mapping. A load or an advance therefore shows on the output one clock after the edge that samples it. The active-low reset is asynchronous on assertion and is released in step with the clock.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `addr_out` is all zeros.
- R2: A low `ld_cpu_n` at a rising edge makes `addr_out` equal the `ext_addr` sampled at that edge, whatever the mode.
- R3: A low `ld_ctl_n` at a rising edge also loads `ext_addr`, and so does the case where both load strobes are low at the same edge.
- R4: With `seq_ilv` = 0 (linear), each advance sets the low two bits to the previous low bits plus one, modulo 4. Start 01 gives 01, 10, 11, 00. Start 11 gives 11, 00, 01, 10.
- R5: With `seq_ilv` = 1 (interleaved), the low two bits on beat k (k = 0..3) equal the start low bits XOR k. Start 10 gives 10, 11, 00, 01.
- R6: Bits ADDR_W-1 down to 2 of `addr_out` keep their loaded value for the whole burst, even when `ext_addr` changes without a load.
- R7: With no load and `adv_n` high, `addr_out` does not change (wait state).
- R8: After the fourth access, one more advance returns the low bits to their starting value, and the sequence repeats.
- R9: A load takes priority over an advance at the same edge. A load in the middle of a burst restarts at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases in step with the clock |
| ld_cpu_n | input | 1 | Active-low load strobe, first source |
| ld_ctl_n | input | 1 | Active-low load strobe, second source |
| adv_n | input | 1 | Active-low burst advance; high inserts a wait state |
| seq_ilv | input | 1 | Burst order: 1 interleaved, 0 linear; static |
| ext_addr | input | ADDR_W | External word address captured on a load |
| addr_out | output | ADDR_W | Current word address to the array |

## Verification
The assertions assume that `seq_ilv` only changes between bursts. A step or hold check that spans a change of the mode input is excused for that cycle. The stimulus changes the mode only at the negative edge just before a load edge, which is the boundary between bursts, so every step the checks look at is taken within a single mode. All inputs are driven on the falling edge, so they are stable when the rising edge samples them.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    SEQ_LINEAR     = 1'b0,
    SEQ_INTERLEAVE = 1'b1
  } seq_mode_e;

  // Low-bit value for a given start and beat index in the selected order.
  function automatic beat_t map_low(input beat_t start, input beat_t idx,
                                    input seq_mode_e mode);
    beat_t r;
    if (mode == SEQ_INTERLEAVE) r = start ^ idx;
    else                        r = start + idx;
    return r;
  endfunction

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nxt;
  end

  assign rst_q_n = chain[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t beat
);
  beat_t beat_q;
  beat_t beat_nxt;
  logic  beat_en;

  always_comb begin
    beat_en  = load | step;
    beat_nxt = beat_q;
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + beat_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_nxt;
  end

  assign beat = beat_q;

  // R9: a load restarts the beat index regardless of step
  assert_beat_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == '0));

  // R7: no load and no step leaves the index alone
  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat));
endmodule

// File: rtl/burst_addr_latch.sv
module burst_addr_latch
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int UP_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [UP_W-1:0]   upper,
  output beat_t             start_low
);
  logic [UP_W-1:0] upper_q,   upper_nxt;
  beat_t           start_q,   start_nxt;

  always_comb begin
    upper_nxt = ext_addr[ADDR_W-1:BEAT_W];
    start_nxt = ext_addr[BEAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load) begin
      upper_q <= upper_nxt;
      start_q <= start_nxt;
    end
  end

  assign upper     = upper_q;
  assign start_low = start_q;

  // R6: upper bits frozen between loads
  assert_upper_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(upper));
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_addr_pkg::*;
(
  input  beat_t     start_low,
  input  beat_t     beat,
  input  seq_mode_e mode,
  output beat_t     low
);
  always_comb begin
    low = map_low(start_low, beat, mode);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int RST_STAGE = 2,
  localparam int UP_W     = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              adv_n,
  input  logic              seq_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_out
);
  logic            rst_q_n;
  logic            load;
  logic            step;
  beat_t           beat;
  beat_t           start_low;
  beat_t           low;
  logic [UP_W-1:0] upper;
  seq_mode_e       mode;

  // Reset releases on a clock edge, asserts immediately.
  burst_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    load = ~ld_cpu_n | ~ld_ctl_n;
    step = ~adv_n & ~load;          // load wins over advance
    mode = seq_mode_e'(seq_ilv);
  end

  burst_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (load),
    .ext_addr  (ext_addr),
    .upper     (upper),
    .start_low (start_low)
  );

  burst_beat_ctr u_beat (
    .clk   (clk),
    .rst_n (rst_q_n),
    .load  (load),
    .step  (step),
    .beat  (beat)
  );

  burst_low_map u_map (
    .start_low (start_low),
    .beat      (beat),
    .mode      (mode),
    .low       (low)
  );

  assign addr_out = {upper, low};

  // R2 / R3: either strobe presents the external address on the next cycle
  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ld_cpu_n || !ld_ctl_n) |=> (addr_out == $past(ext_addr)));

  // R4: linear order increments the low bits by one
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_cpu_n && ld_ctl_n && !adv_n && !seq_ilv) |=>
      (seq_ilv != $past(seq_ilv)) ||
      (addr_out[1:0] == beat_t'($past(addr_out[1:0]) + beat_t'(1))));

  // R5: interleaved order always flips bit 0 on a step
  assert_ilv_step_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_cpu_n && ld_ctl_n && !adv_n && seq_ilv) |=>
      (seq_ilv != $past(seq_ilv)) ||
      (addr_out[0] != $past(addr_out[0])));

  // R7: wait state repeats the address
  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_cpu_n && ld_ctl_n && adv_n) |=>
      (seq_ilv != $past(seq_ilv)) || $stable(addr_out));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 16;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_cpu_n, ld_ctl_n, adv_n, seq_ilv;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr_out;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk (clk), .rst_n (rst_n), .ld_cpu_n (ld_cpu_n), .ld_ctl_n (ld_ctl_n),
    .adv_n (adv_n), .seq_ilv (seq_ilv), .ext_addr (ext_addr), .addr_out (addr_out)
  );

  // {mode, ld_cpu_n, ld_ctl_n, adv_n, ext_addr, expected}
  localparam logic [35:0] VEC [NV] = '{
    {4'b0_0_1_1, 16'h1235, 16'h1235},  // 0 R2 load, linear
    {4'b0_1_1_0, 16'h0000, 16'h1236},  // 1 R4
    {4'b0_1_1_1, 16'h7777, 16'h1236},  // 2 R7 wait
    {4'b0_1_1_0, 16'h0000, 16'h1237},  // 3 R4
    {4'b0_1_1_0, 16'h0000, 16'h1234},  // 4 R4
    {4'b0_1_1_0, 16'h0000, 16'h1235},  // 5 R8 wrap
    {4'b0_1_0_1, 16'hABCF, 16'hABCF},  // 6 R3 load
    {4'b0_1_1_0, 16'h0000, 16'hABCC},  // 7 R4 start 11
    {4'b0_1_1_0, 16'h0000, 16'hABCD},  // 8 R4
    {4'b0_1_1_0, 16'h0000, 16'hABCE},  // 9 R4
    {4'b1_0_1_1, 16'h5552, 16'h5552},  // 10 R2 load, interleaved
    {4'b1_1_1_0, 16'h0000, 16'h5553},  // 11 R5
    {4'b1_1_1_0, 16'h0000, 16'h5550},  // 12 R5
    {4'b1_1_1_1, 16'h0000, 16'h5550},  // 13 R7
    {4'b1_1_1_0, 16'h0000, 16'h5551},  // 14 R5
    {4'b1_1_1_0, 16'h0000, 16'h5552},  // 15 R8 wrap
    {4'b1_1_1_0, 16'h0000, 16'h5553},  // 16 R5
    {4'b1_0_1_0, 16'h00F1, 16'h00F1},  // 17 R9 load beats advance
    {4'b1_1_1_0, 16'h0000, 16'h00F0},  // 18 R9 restart at beat 1
    {4'b1_0_0_0, 16'hFFFF, 16'hFFFF},  // 19 R3 both strobes
    {4'b1_1_1_0, 16'h0000, 16'hFFFE},  // 20 R5
    {4'b1_1_1_0, 16'h0000, 16'hFFFD}   // 21 R5
  };

  function automatic string req_of(input int i);
    case (i)
      0, 10:             return "R2";
      6, 19:             return "R3";
      2, 13:             return "R7";
      5, 15:             return "R8";
      17, 18:            return "R9";
      1, 3, 4, 7, 8, 9:  return "R4";
      default:           return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_run++;
    if (addr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic idle();
    ld_cpu_n = 1'b1; ld_ctl_n = 1'b1; adv_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); seq_ilv = 1'b1; ext_addr = 16'hDEAD;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);                   // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 16'h0000);                   // R1 after release, no load

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      seq_ilv  = VEC[i][35];
      ld_cpu_n = VEC[i][34];
      ld_ctl_n = VEC[i][33];
      adv_n    = VEC[i][32];
      ext_addr = VEC[i][31:16];
      @(posedge clk); #1;
      check(req_of(i), VEC[i][15:0]);
    end

    // R6: ext_addr changes without a load do not reach the upper bits
    @(negedge clk); idle(); seq_ilv = 1'b0; ld_cpu_n = 1'b0; ext_addr = 16'h8000;
    @(posedge clk); #1; check("R6", 16'h8000);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk); idle(); adv_n = 1'b0; ext_addr = 16'h7FFF - 16'(k);
      @(posedge clk); #1; check("R6", 16'h8000 | 16'(k % 4));
    end

    // R9: mid-burst reload from the other strobe, linear
    @(negedge clk); idle(); adv_n = 1'b0;
    @(posedge clk); #1; check("R4", 16'h8001);
    @(negedge clk); idle(); adv_n = 1'b0; ld_ctl_n = 1'b0; ext_addr = 16'h4442;
    @(posedge clk); #1; check("R9", 16'h4442);
    @(negedge clk); idle(); adv_n = 1'b0;
    @(posedge clk); #1; check("R9", 16'h4443);

    // R1: reset in the middle of a burst clears the address
    @(negedge clk); idle(); rst_n = 1'b0;
    #1 check("R1", 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule